// File: doc/BRIEF.md
# Gated Up/Down Timer

This block is a 16-bit general-purpose timer whose count rate comes from a power-of-two prescaler on the system clock. A small run-control state machine decides whether each prescaler tick advances the counter. Three inputs feed that decision: a software run bit, a 3-bit mode field, and an external gate pin. The gate pin's active level is chosen by the lowest mode bit. The count direction is a software bit. It can optionally be flipped by an external direction pin. Software may load the counter at any time.

The gate and direction pins are asynchronous. Each passes through a two-flop synchronizer. Every time the counter wraps, the block pulses an interrupt request and a trigger line for neighbouring timers, each for one cycle, and a toggle latch output changes state. A wrap is a step up from 0xFFFF or a step down from 0x0000. Changes on the gate pin never raise a request by themselves.

The run-control machine has three states:
- `ST_STOP`: the run bit is clear, or the mode is not a timer mode.
- `ST_WAIT`: the block is armed in a gated mode, but the gate is inactive.
- `ST_RUN`: ticks advance the counter.

Its transitions:
- `arm`: from `ST_STOP` to `ST_WAIT` or to `ST_RUN`.
- `gate_open`: from `ST_WAIT` to `ST_RUN`.
- `gate_close`: from `ST_RUN` to `ST_WAIT`.
- `halt`: from any state to `ST_STOP`.

The next state is recomputed every cycle from the synchronized inputs.

Top module: `gated_updown_timer`

## Requirements
- R1: After reset the count is 0x0000, and `toggle_out`, `irq` and `trig` are all 0.
- R2: With prescaler select N (0 to 7) and the counter running, the count changes by exactly one every 2^(N+3) clock cycles.
- R3: Mode 3'b000 (free timer) counts whenever `run` is 1, whatever the level of `gate_in`.
- R4: Mode 3'b010 counts only while the synchronized `gate_in` is 0. A 1 on the gate holds the count.
- R5: Mode 3'b011 counts only while the synchronized `gate_in` is 1. A 0 on the gate holds the count.
- R6: With `run` at 0 in any mode, the count holds. With a mode other than 000, 010 or 011, the count also holds.
- R7: The count direction is down when `down ^ (ext_dir_en & dir_in)` is 1 and up otherwise. A 1 on `down` means count down.
- R8: A step up from 0xFFFF gives 0x0000. It pulses `irq` and `trig` high for exactly one cycle and inverts `toggle_out`, with all three becoming visible together with the new count.
- R9: A step down from 0x0000 gives 0xFFFF, with the same `irq`, `trig` and `toggle_out` behaviour as R8.
- R10: Transitions of `gate_in` alone never assert `irq`.
- R11: When `cnt_wr` is 1, the counter takes `cnt_wdata` on the next edge. This load wins over a count step due in the same cycle, and the load never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operating mode field; bit 0 sets the active gate level in gated modes |
| presc_sel | input | 3 | Prescaler select N; rate is clk / 2^(N+3) |
| run | input | 1 | Software run bit |
| down | input | 1 | Software direction bit, 1 = down |
| ext_dir_en | input | 1 | Lets `dir_in` invert the direction |
| gate_in | input | 1 | Asynchronous external gate |
| dir_in | input | 1 | Asynchronous external direction input |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 16 | Counter load value |
| count | output | 16 | Current counter value |
| toggle_out | output | 1 | Toggle latch, inverted on every wrap |
| trig | output | 1 | One-cycle trigger to neighbouring timers on every wrap |
| irq | output | 1 | One-cycle interrupt request on every wrap |

## Verification
Several properties are checked by assertions on every cycle:
- The prescaler tick is a single-cycle pulse.
- The counter moves only after a load or an enabled tick.
- `irq` is always preceded by a counting step, so a gate edge alone cannot raise it.
- The request is one cycle wide and coincides with a change of the toggle latch.
- `ST_RUN` is reached only with `run` set.

Other behaviours can only be shown by the bench scenarios:
- the exact step period for each prescaler setting;
- the mode-by-gate-level counting table;
- the four-way direction truth table;
- the wrap values;
- the precedence of a load over a step in the same cycle.

// File: rtl/gut_pkg.sv
package gut_pkg;
    localparam int CNT_W   = 16;
    localparam int MODE_W  = 3;
    localparam int PSEL_W  = 3;
    localparam int PS_BASE = 3;

    localparam logic [MODE_W-1:0] MODE_FREE   = 3'b000;
    localparam logic [MODE_W-1:0] MODE_GATE_L = 3'b010;
    localparam logic [MODE_W-1:0] MODE_GATE_H = 3'b011;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } run_state_t;
endpackage

// File: rtl/gut_sync.sv
module gut_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[s] <= '0;
                end else if (s == 0) begin
                    stg_q[s] <= async_i;
                end else begin
                    stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gut_prescaler.sv
module gut_prescaler #(
    parameter int SEL_W = 3,
    parameter int BASE  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PC_W = BASE + (1 << SEL_W) - 1;
    localparam int SH_W = $clog2(PC_W + 1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + PC_W'(1);
    end

    always_comb begin
        mask = (PC_W'(1) << (SH_W'(sel) + SH_W'(BASE))) - PC_W'(1);
        tick = &(pc_q | ~mask);
    end

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/gut_runctl.sv
module gut_runctl
    import gut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              gate_s,
    output logic              cnt_en
);
    run_state_t state_q, state_d;
    logic       is_gated, is_timer, gate_ok;

    always_comb begin
        is_gated = (mode_i == MODE_GATE_L) || (mode_i == MODE_GATE_H);
        is_timer = is_gated || (mode_i == MODE_FREE);
        gate_ok  = !is_gated || (gate_s == mode_i[0]);
        state_d  = state_q;
        unique case (state_q)
            ST_STOP: if (run_i && is_timer)      state_d = gate_ok ? ST_RUN : ST_WAIT;
            ST_WAIT: if (!run_i || !is_timer)    state_d = ST_STOP;
                     else if (gate_ok)           state_d = ST_RUN;
            ST_RUN:  if (!run_i || !is_timer)    state_d = ST_STOP;
                     else if (!gate_ok)          state_d = ST_WAIT;
            default:                             state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  cnt_en = 1'b1;
            default: cnt_en = 1'b0;
        endcase
    end

    // R6
    run_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> $past(run_i));
endmodule

// File: rtl/gut_core.sv
module gut_core
    import gut_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             down_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tgl_o,
    output logic             irq_o,
    output logic             trig_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             tgl_q, irq_q, trig_q;
    logic             wrap;

    always_comb begin
        wrap = step_i && !wr_i &&
               (down_i ? (cnt_q == '0) : (cnt_q == CNT_MAX));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tgl_q  <= 1'b0;
            irq_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            if (wr_i)        cnt_q <= wdata_i;
            else if (step_i) cnt_q <= down_i ? cnt_q - CNT_W'(1) : cnt_q + CNT_W'(1);
            if (wrap)        tgl_q <= ~tgl_q;
            irq_q  <= wrap;
            trig_q <= wrap;
        end
    end

    assign cnt_o  = cnt_q;
    assign tgl_o  = tgl_q;
    assign irq_o  = irq_q;
    assign trig_o = trig_q;

    // R11
    cnt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> $past(wr_i || step_i));
    // R10
    irq_from_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(step_i && !wr_i));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R9
    toggle_with_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_q != $past(tgl_q)) |-> trig_q);
endmodule

// File: rtl/gated_updown_timer.sv
module gated_updown_timer
    import gut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic              run,
    input  logic              down,
    input  logic              ext_dir_en,
    input  logic              gate_in,
    input  logic              dir_in,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  count,
    output logic              toggle_out,
    output logic              trig,
    output logic              irq
);
    logic [1:0] pins_s;
    logic       tick, cnt_en, step, dir_dn;

    gut_sync #(.W(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({dir_in, gate_in}), .sync_o(pins_s)
    );

    gut_prescaler #(.SEL_W(PSEL_W), .BASE(PS_BASE)) u_presc (
        .clk(clk), .rst_n(rst_n), .sel(presc_sel), .tick(tick)
    );

    gut_runctl u_ctl (
        .clk(clk), .rst_n(rst_n), .run_i(run), .mode_i(mode),
        .gate_s(pins_s[0]), .cnt_en(cnt_en)
    );

    assign step   = tick && cnt_en;
    assign dir_dn = down ^ (ext_dir_en & pins_s[1]);

    gut_core u_core (
        .clk(clk), .rst_n(rst_n), .step_i(step), .down_i(dir_dn),
        .wr_i(cnt_wr), .wdata_i(cnt_wdata), .cnt_o(count),
        .tgl_o(toggle_out), .irq_o(irq), .trig_o(trig)
    );
endmodule

// File: tb/gated_updown_timer_tb.sv
`timescale 1ns/1ps
module gated_updown_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'b000, presc_sel = 3'd0;
    logic        run = 1'b0, down = 1'b0, ext_dir_en = 1'b0;
    logic        gate_in = 1'b0, dir_in = 1'b0, cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = 16'h0;
    logic [15:0] count;
    logic        toggle_out, trig, irq;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    gated_updown_timer u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .presc_sel(presc_sel),
        .run(run), .down(down), .ext_dir_en(ext_dir_en), .gate_in(gate_in),
        .dir_in(dir_in), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .count(count), .toggle_out(toggle_out), .trig(trig), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align(output bit ok);
        logic [15:0] prev;
        prev = count;
        ok = 1'b0;
        for (int i = 0; i < 2200; i++) begin
            @(negedge clk);
            if (count != prev) begin ok = 1'b1; break; end
        end
    endtask

    task automatic write_cnt(input logic [15:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit          ok;
        logic [15:0] st, d;
        int          irqs;
        logic        t0;

        settle(3);
        // R1: reset state
        chk(count == 16'h0 && !toggle_out && !irq && !trig, "R1", count, 0);
        rst_n = 1'b1;
        settle(3);

        // R2: rate sweep over every prescaler setting, counting up
        run = 1'b1; mode = 3'b000;
        for (int n = 0; n < 8; n++) begin
            presc_sel = 3'(n);
            settle(4);
            align(ok);
            st = count;
            settle(3 * (1 << (n + 3)));
            d = count - st;
            chk(ok && d == 16'd3, "R2 up", d, 3);
        end
        // R2/R7: rate counting down
        down = 1'b1;
        for (int n = 0; n < 3; n++) begin
            presc_sel = 3'(n);
            settle(4);
            align(ok);
            st = count;
            settle(4 * (1 << (n + 3)));
            d = st - count;
            chk(ok && d == 16'd4, "R2 down", d, 4);
        end
        down = 1'b0; presc_sel = 3'd0;

        // R3 R4 R5 R6: exhaustive mode x gate x run table
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 8; m++) begin
                for (int g = 0; g < 2; g++) begin
                    bit exp_cnt;
                    string tag;
                    run = r[0]; mode = 3'(m); gate_in = g[0];
                    exp_cnt = (r == 1) && ((m == 0) || (m == 2 && g == 0) || (m == 3 && g == 1));
                    tag = (r == 0) ? "R6 run=0" : (m == 0) ? "R3" : (m == 2) ? "R4" :
                          (m == 3) ? "R5" : "R6 mode";
                    settle(12);
                    st = count;
                    settle(64);
                    d = count - st;
                    chk(d == (exp_cnt ? 16'd8 : 16'd0), tag, d, exp_cnt ? 8 : 0);
                end
            end
        end

        // R7: direction truth table
        run = 1'b1; mode = 3'b000;
        for (int v = 0; v < 8; v++) begin
            bit dn;
            down = v[0]; ext_dir_en = v[1]; dir_in = v[2];
            dn = v[0] ^ (v[1] & v[2]);
            settle(12);
            st = count;
            settle(64);
            d = dn ? st - count : count - st;
            chk(d == 16'd8, "R7", d, 8);
        end
        down = 1'b0; ext_dir_en = 1'b0; dir_in = 1'b0;

        // R8: overflow
        settle(2);
        write_cnt(16'hFFFD);
        t0 = toggle_out; irqs = 0; st = 16'h1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq) begin
                irqs++; st = count;
                chk(trig && toggle_out != t0, "R8 trig/toggle", {trig, toggle_out}, {1'b1, ~t0});
            end
        end
        chk(irqs == 1, "R8 irq pulses", irqs, 1);
        chk(st == 16'h0000, "R8 wrap value", st, 0);

        // R9: underflow
        down = 1'b1;
        write_cnt(16'h0002);
        t0 = toggle_out; irqs = 0; st = 16'h1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq) begin
                irqs++; st = count;
                chk(trig && toggle_out != t0, "R9 trig/toggle", {trig, toggle_out}, {1'b1, ~t0});
            end
        end
        chk(irqs == 1, "R9 irq pulses", irqs, 1);
        chk(st == 16'hFFFF, "R9 wrap value", st, 16'hFFFF);
        down = 1'b0;

        // R10: gate activity alone, counter parked at the top with run off
        run = 1'b0; mode = 3'b010;
        write_cnt(16'hFFFF);
        irqs = 0;
        for (int i = 0; i < 60; i++) begin
            gate_in = ~gate_in;
            settle(3);
            if (irq) irqs++;
        end
        chk(irqs == 0 && count == 16'hFFFF, "R10", irqs, 0);

        // R11: load held across several ticks wins every time
        run = 1'b1; mode = 3'b000;
        cnt_wr = 1'b1; cnt_wdata = 16'h1234;
        @(negedge clk);
        irqs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (count != 16'h1234) irqs++;
        end
        chk(irqs == 0, "R11 load precedence", irqs, 0);
        cnt_wdata = 16'hFFFF;
        irqs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (irq || count != 16'hFFFF) irqs++;
        end
        chk(irqs == 0, "R11 no irq on load", irqs, 0);
        cnt_wr = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule